// File: doc/BRIEF.md
# Dual GPIO Port with Pattern-Mismatch Event

This block holds the software-visible state of two 8-bit bidirectional pin groups. For every pin it keeps an output latch bit, a drive-style bit (open-drain or push-pull) and an input-style bit (digital or analog). From these it produces the pin-level controls: output value, output enable and weak-pullup enable. It also returns the pin levels to software through a byte-wide register bus.

Each port also has a mask and a pattern register. The block compares the synchronized pin levels against the pattern wherever the mask bit is set. A mismatch on either port raises a single registered event. The event always raises a wake request toward a suspended clock source. It raises an interrupt request only when software has set an enable bit. The event is a level: it stays up while the pins disagree with the pattern and drops when they agree again.

Top module: `gpio_match_port`

## Requirements
- R1: After reset every latch bit is 1, every input-style bit is 1 (digital), every drive-style bit is 0 (open-drain), every mask is 0x00, every pattern is 0xFF and the interrupt enable is 0. So pin_oe is all 0, pin_out and pin_pu are all 1, and match_evt, irq_req and wake_req are all 0.
- R2: For a digital pin, latch 0 gives pin_oe=1 with pin_out=0. Latch 1 with drive-style 1 (push-pull) gives pin_oe=1 with pin_out=1. Latch 1 with drive-style 0 (open-drain) gives pin_oe=0.
- R3: A pin whose input-style bit is 0 (analog) has pin_oe=0 and pin_pu=0 whatever its latch holds. A digital pin has pin_pu equal to its latch bit.
- R4: Reading a port's latch address returns the pin levels, not the latch contents. Each level passes through two flip-flops, so a change on pin_in shows on reg_rdata after the second rising clock edge.
- R5: For each port a mismatch exists when (pins AND mask) differs from (pattern AND mask). match_evt is the registered OR of both ports' mismatches. It rises on the third rising edge after the pin change, or on the first edge after the register write that creates the mismatch.
- R6: match_evt is a level with no sticky state. It returns to 0 once the masked pins agree with the pattern again, with the same latency as in R5.
- R7: irq_req is 1 only while match_evt is 1 and the interrupt enable is set. The enable is bit 1 of the control register at address 0xF; other bits written there are dropped and read back as 0.
- R8: wake_req follows match_evt whatever the interrupt enable holds.
- R9: An analog pin enters both the read-back and the mismatch comparison as 0, so switching a pin to analog can clear a mismatch it caused.
- R10: Port p occupies addresses 8*p+0 (latch write / pin read), +1 (drive-style), +2 (input-style), +3 (mask) and +4 (pattern), and 0xF is the control register. Addresses 5, 6, 7, 13 and 14 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe, one byte per cycle |
| reg_addr | input | 4 | Register byte address for both reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pin_in | input | 16 | Pin levels; bits 7:0 are port 0, bits 15:8 are port 1 |
| pin_out | output | 16 | Value driven on each pin when enabled |
| pin_oe | output | 16 | Output driver enable per pin |
| pin_pu | output | 16 | Weak pullup enable per pin |
| match_evt | output | 1 | Registered pattern-mismatch event |
| irq_req | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake request for the suspended clock source |

## Verification
The bench checks the event at its exact edge: one edge early and on the edge itself after a pin change. A missing or extra synchronizer stage would show up as a shifted rise. It clears the mismatch first by restoring the pins and then by switching the offending pin to analog. A sticky flag, or a comparison taken before input gating, would leave the event stuck high. It sets the control register with bit 0 alone to catch a decoder that looks at the wrong bit. It reads the latch address while the latch and the pins differ, which exposes a design that returns the latch. It writes to the unused addresses and then reads the neighbouring registers, which exposes an address decode that aliases them.

// File: rtl/gpio_match_pkg.sv
package gpio_match_pkg;
  localparam int unsigned PORT_W    = 8;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned SLOT_W    = 3;  // per-port stride of 2**SLOT_W bytes
  localparam int unsigned IRQ_EN_BIT = 1;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_LATCH = 3'd0,
    SLOT_DRIVE = 3'd1,
    SLOT_MODE  = 3'd2,
    SLOT_MASK  = 3'd3,
    SLOT_PATT  = 3'd4
  } slot_e;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'hF;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic stage_q, out_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_o = out_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] push_pull_i,
  input  logic [WIDTH-1:0] digital_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] pu_o,
  output logic [WIDTH-1:0] level_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      out_o[b]   = latch_i[b];
      // A low latch always drives; a high latch drives only in push-pull.
      oe_o[b]    = digital_i[b] & (~latch_i[b] | push_pull_i[b]);
      pu_o[b]    = digital_i[b] & latch_i[b];
      // Analog pins have no receiver: they present 0.
      level_o[b] = digital_i[b] & pin_sync_i[b];
    end
  end
endmodule

// File: rtl/gpio_match_detect.sv
module gpio_match_detect #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned WIDTH     = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PORTS-1:0][WIDTH-1:0]  level_i,
  input  logic [NUM_PORTS-1:0][WIDTH-1:0]  mask_i,
  input  logic [NUM_PORTS-1:0][WIDTH-1:0]  patt_i,
  output logic                             evt_o
);
  logic [NUM_PORTS-1:0] port_miss;
  logic                 evt_d, evt_q;
  logic                 masks_clear;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_miss[p] = (level_i[p] & mask_i[p]) != (patt_i[p] & mask_i[p]);
  end

  always_comb begin
    evt_d = |port_miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign evt_o       = evt_q;
  assign masks_clear = (mask_i == '0);

  // R5: with every mask clear for two cycles no event can be present.
  p_masks_clear_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (masks_clear && $past(masks_clear)) |-> !evt_o);
endmodule

// File: rtl/gpio_match_port.sv
module gpio_match_port
  import gpio_match_pkg::*;
#(
  parameter int unsigned NUM_PORTS = gpio_match_pkg::NUM_PORTS,
  parameter int unsigned PORT_W    = gpio_match_pkg::PORT_W,
  parameter int unsigned ADDR_W    = gpio_match_pkg::ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [PORT_W-1:0]           reg_wdata,
  output logic [PORT_W-1:0]           reg_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  output logic [NUM_PORTS*PORT_W-1:0] pin_pu,
  output logic                        match_evt,
  output logic                        irq_req,
  output logic                        wake_req
);
  localparam int unsigned PSEL_W = ADDR_W - SLOT_W;
  localparam int unsigned PINS   = NUM_PORTS * PORT_W;

  logic rst_sync_n;

  logic [NUM_PORTS-1:0][PORT_W-1:0] latch_q, latch_d;
  logic [NUM_PORTS-1:0][PORT_W-1:0] drive_q, drive_d;
  logic [NUM_PORTS-1:0][PORT_W-1:0] mode_q,  mode_d;
  logic [NUM_PORTS-1:0][PORT_W-1:0] mask_q,  mask_d;
  logic [NUM_PORTS-1:0][PORT_W-1:0] patt_q,  patt_d;
  logic                             irq_en_q, irq_en_d;

  logic [NUM_PORTS-1:0][PORT_W-1:0] level;
  logic [PINS-1:0]                  pin_sync;

  logic [PSEL_W-1:0] addr_port;
  logic [SLOT_W-1:0] addr_slot;
  logic              addr_ctrl;

  assign addr_port = reg_addr[ADDR_W-1:SLOT_W];
  assign addr_slot = reg_addr[SLOT_W-1:0];
  assign addr_ctrl = (reg_addr == CTRL_ADDR);

  gpio_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(PINS)) i_in_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (pin_in),
    .q_o   (pin_sync)
  );

  // Register next-state.
  always_comb begin
    latch_d  = latch_q;
    drive_d  = drive_q;
    mode_d   = mode_q;
    mask_d   = mask_q;
    patt_d   = patt_q;
    irq_en_d = irq_en_q;
    if (reg_we) begin
      if (addr_ctrl) begin
        irq_en_d = reg_wdata[IRQ_EN_BIT];
      end else begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (int'(addr_port) == p) begin
            case (addr_slot)
              SLOT_LATCH: latch_d[p] = reg_wdata;
              SLOT_DRIVE: drive_d[p] = reg_wdata;
              SLOT_MODE:  mode_d[p]  = reg_wdata;
              SLOT_MASK:  mask_d[p]  = reg_wdata;
              SLOT_PATT:  patt_d[p]  = reg_wdata;
              default:    ;
            endcase
          end
        end
      end
    end
  end

  // Register state.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      latch_q  <= '1;
      drive_q  <= '0;
      mode_q   <= '1;
      mask_q   <= '0;
      patt_q   <= '1;
      irq_en_q <= 1'b0;
    end else begin
      latch_q  <= latch_d;
      drive_q  <= drive_d;
      mode_q   <= mode_d;
      mask_q   <= mask_d;
      patt_q   <= patt_d;
      irq_en_q <= irq_en_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_pin_ctrl #(.WIDTH(PORT_W)) i_pin_ctrl (
      .latch_i     (latch_q[p]),
      .push_pull_i (drive_q[p]),
      .digital_i   (mode_q[p]),
      .pin_sync_i  (pin_sync[p*PORT_W +: PORT_W]),
      .out_o       (pin_out[p*PORT_W +: PORT_W]),
      .oe_o        (pin_oe[p*PORT_W +: PORT_W]),
      .pu_o        (pin_pu[p*PORT_W +: PORT_W]),
      .level_o     (level[p])
    );

    for (genvar b = 0; b < PORT_W; b++) begin : g_chk
      // R3: analog pins neither drive nor pull up.
      p_analog_quiet_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !mode_q[p][b] |-> (!pin_oe[p*PORT_W+b] && !pin_pu[p*PORT_W+b]));
      // R2: a low latch on a digital pin always drives low.
      p_low_latch_drives_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (mode_q[p][b] && !latch_q[p][b]) |-> (pin_oe[p*PORT_W+b] && !pin_out[p*PORT_W+b]));
    end
  end

  gpio_match_detect #(.NUM_PORTS(NUM_PORTS), .WIDTH(PORT_W)) i_match (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .level_i (level),
    .mask_i  (mask_q),
    .patt_i  (patt_q),
    .evt_o   (match_evt)
  );

  assign irq_req  = match_evt & irq_en_q;
  assign wake_req = match_evt;

  // Read path.
  always_comb begin
    reg_rdata = '0;
    if (addr_ctrl) begin
      reg_rdata[IRQ_EN_BIT] = irq_en_q;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (int'(addr_port) == p) begin
          case (addr_slot)
            SLOT_LATCH: reg_rdata = level[p];
            SLOT_DRIVE: reg_rdata = drive_q[p];
            SLOT_MODE:  reg_rdata = mode_q[p];
            SLOT_MASK:  reg_rdata = mask_q[p];
            SLOT_PATT:  reg_rdata = patt_q[p];
            default:    reg_rdata = '0;
          endcase
        end
      end
    end
  end

  // R7: no interrupt request without the enable.
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |-> irq_en_q);
  // R8: an interrupt request always comes with a wake request.
  p_irq_implies_wake_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |-> wake_req);
endmodule

// File: tb/test_gpio_match_port.sv
`timescale 1ns/1ps
module test_gpio_match_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out, pin_oe, pin_pu;
  logic        match_evt, irq_req, wake_req;

  localparam int SEL_RD = 0, SEL_OE = 1, SEL_OUT = 2, SEL_PU = 3, SEL_FLAGS = 4;

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  gpio_match_port i_gpio_match_port (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .match_evt(match_evt), .irq_req(irq_req), .wake_req(wake_req)
  );

  function automatic logic [15:0] observe(int sel);
    case (sel)
      SEL_RD:  return {8'h00, reg_rdata};
      SEL_OE:  return pin_oe;
      SEL_OUT: return pin_out;
      SEL_PU:  return pin_pu;
      default: return {13'd0, match_evt, irq_req, wake_req};
    endcase
  endfunction

  // Monitor: pops expectations and compares them away from the active edge.
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = sb.pop_front();
      act = observe(it.sel);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    step(1);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic expect_item(string req, int sel, logic [3:0] a, logic [15:0] e);
    item_t it;
    reg_addr = a;
    it.req = req; it.sel = sel; it.exp = e;
    sb.push_back(it);
    @(negedge clk);
    #2;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; pin_in = 16'h0000;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1: reset state
    expect_item("R1", SEL_RD, 4'h1, 16'h0000);
    expect_item("R1", SEL_RD, 4'h2, 16'h00FF);
    expect_item("R1", SEL_RD, 4'hB, 16'h0000);
    expect_item("R1", SEL_RD, 4'hC, 16'h00FF);
    expect_item("R1", SEL_RD, 4'hF, 16'h0000);
    expect_item("R1", SEL_RD, 4'h0, 16'h0000);
    expect_item("R1", SEL_OE, 4'h0, 16'h0000);
    expect_item("R1", SEL_OUT, 4'h0, 16'hFFFF);
    expect_item("R1", SEL_PU, 4'h0, 16'hFFFF);
    expect_item("R1", SEL_FLAGS, 4'h0, 16'h0000);

    // R2: drive styles on port 0
    wr(4'h0, 8'h0F);
    wr(4'h1, 8'h03);
    expect_item("R2", SEL_OE, 4'h0, 16'h00F3);
    expect_item("R2", SEL_OUT, 4'h0, 16'hFF0F);
    expect_item("R3", SEL_PU, 4'h0, 16'hFF0F);

    // R4: live, synchronized pin read, not the latch
    pin_in = 16'hA55A;
    step(1);
    expect_item("R4", SEL_RD, 4'h0, 16'h0000);
    step(1);
    expect_item("R4", SEL_RD, 4'h0, 16'h005A);
    expect_item("R4", SEL_RD, 4'h8, 16'h00A5);

    // R3: analog pins
    wr(4'h2, 8'hF0);
    expect_item("R3", SEL_RD, 4'h0, 16'h0050);
    expect_item("R3", SEL_OE, 4'h0, 16'h00F0);
    expect_item("R3", SEL_PU, 4'h0, 16'hFF00);
    wr(4'h2, 8'hFF);

    // R5: per-port compare, mismatch on port 1
    wr(4'hB, 8'h0F);
    wr(4'hC, 8'h05);
    step(1);
    expect_item("R5", SEL_FLAGS, 4'h0, 16'h0000);
    wr(4'hC, 8'h06);
    step(1);
    expect_item("R8", SEL_FLAGS, 4'h0, 16'h0005);

    // R7: interrupt enable bit 1 only
    wr(4'hF, 8'h02);
    expect_item("R7", SEL_FLAGS, 4'h0, 16'h0007);
    wr(4'hF, 8'h01);
    expect_item("R7", SEL_FLAGS, 4'h0, 16'h0005);
    expect_item("R7", SEL_RD, 4'hF, 16'h0000);
    wr(4'hF, 8'h02);
    expect_item("R7", SEL_RD, 4'hF, 16'h0002);

    // R6: level behaviour, clears with pattern and with pins
    wr(4'hC, 8'h05);
    step(1);
    expect_item("R6", SEL_FLAGS, 4'h0, 16'h0000);
    pin_in = 16'hA75A;
    step(2);
    expect_item("R5", SEL_FLAGS, 4'h0, 16'h0000);
    step(1);
    expect_item("R5", SEL_FLAGS, 4'h0, 16'h0007);
    pin_in = 16'hA55A;
    step(2);
    expect_item("R6", SEL_FLAGS, 4'h0, 16'h0007);
    step(1);
    expect_item("R6", SEL_FLAGS, 4'h0, 16'h0000);

    // R5: port 0 contributes through the OR
    wr(4'h3, 8'h80);
    wr(4'h4, 8'h00);
    step(1);
    expect_item("R5", SEL_FLAGS, 4'h0, 16'h0000);
    pin_in = 16'hA5DA;
    step(3);
    expect_item("R5", SEL_FLAGS, 4'h0, 16'h0007);
    pin_in = 16'hA55A;
    step(3);
    expect_item("R6", SEL_FLAGS, 4'h0, 16'h0000);

    // R9: analog pin compares as 0
    wr(4'h3, 8'h00);
    pin_in = 16'hA55B;
    step(3);
    wr(4'h3, 8'h01);
    step(1);
    expect_item("R9", SEL_FLAGS, 4'h0, 16'h0007);
    expect_item("R9", SEL_RD, 4'h0, 16'h005B);
    wr(4'h2, 8'hFE);
    step(1);
    expect_item("R9", SEL_FLAGS, 4'h0, 16'h0000);
    expect_item("R9", SEL_RD, 4'h0, 16'h005A);
    expect_item("R3", SEL_OE, 4'h0, 16'h00F2);

    // R10: unmapped addresses
    wr(4'h6, 8'hAA);
    wr(4'hE, 8'h55);
    expect_item("R10", SEL_RD, 4'h6, 16'h0000);
    expect_item("R10", SEL_RD, 4'hE, 16'h0000);
    expect_item("R10", SEL_RD, 4'hC, 16'h0005);
    expect_item("R10", SEL_RD, 4'h1, 16'h0003);
    expect_item("R10", SEL_RD, 4'hF, 16'h0002);
    expect_item("R10", SEL_RD, 4'hB, 16'h000F);

    step(2);
    done = 1;
    report();
  end
endmodule